// File: doc/BRIEF.md
# Shift-In Prefetch Word Queue

This block is a word queue placed between a shared-memory read port and a streaming consumer such as an instruction fetcher or a pixel streamer. Memory words arrive in bursts whenever the port is granted a slot. The consumer takes them out at any steady rate, up to one word on every clock. The queue holds up to twenty 32-bit words. That is enough to carry a consumer that drains at full rate across the sixteen-clock gap before the next memory slot arrives.

The storage is a chain of registers, and the oldest word always sits in stage 0. On every clock, each stage either keeps its word, takes the word from the stage above it, or takes the incoming memory word. A single occupancy count serves two purposes: it gives the fill level, and it selects the stage where the next word is written. A word written into an empty queue appears at the head one clock later, so the consumer can start as soon as the first word is written. A flush input drops all held words in one clock, for example after a branch or at the start of a new stream.

Top module: `prefetch_queue`

## Requirements
- R1: After reset, `level` is 0, `empty` is 1 and `full` is 0.
- R2: A write (`wrValid` high, no flush) with `level` below 20 stores `wrData` behind all held words and raises `level` by one on the next clock. A word written into an empty queue is on `headData` one clock later.
- R3: A read (`rdStrobe` high, no flush) with `level` above 0 removes the head word and lowers `level` by one. The next older word appears on `headData` on the next clock. Reads may be issued on every consecutive clock.
- R4: A read and a write in the same clock with `level` above 0 leave `level` unchanged and keep the arrival order. This also holds at `level` 20.
- R5: A write with no read while `level` is 20 is ignored: `level` stays 20 and the held words and their order are unchanged.
- R6: A read while `level` is 0 is ignored. If a write arrives in the same clock, that word is still stored and `level` becomes 1.
- R7: `flush` high sets `level` to 0 on the next clock, and any read or write in that same clock is discarded.
- R8: `empty` is 1 exactly when `level` is 0, and `full` is 1 exactly when `level` is 20.
- R9: Under any mix of reads and writes, `headData` (whenever `empty` is 0) is the oldest word stored and not yet read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Drop all held words |
| wrValid | input | 1 | Memory word present on `wrData` |
| wrData | input | 32 | Incoming memory word |
| rdStrobe | input | 1 | Consumer takes the head word |
| headData | output | 32 | Oldest held word; valid when `empty` is 0 |
| empty | output | 1 | No word held |
| full | output | 1 | Twenty words held |
| level | output | 5 | Number of held words |

## Verification
The assertions check on every cycle how `level` responds to each mix of read, write and flush: increment, decrement, hold on a paired read and write, and hold when a write meets a full queue or a read meets an empty one. They also check that a loaded word lands in the stage it was aimed at and that a shift brings stage 1 to the head. Only the bench scenarios show that word order survives long random mixes and that the data are correct at every fill level from 0 to 20 under each input combination. That sweep compares the outputs against a queue model.

// File: rtl/pq_pkg.sv
package pq_pkg;
  // Per-clock command from control to the stage chain
  typedef struct packed {
    logic shift;  // every stage takes the word from the stage above
    logic load;   // the stage named by the write index takes the memory word
  } pqStepT;
endpackage

// File: rtl/pq_ctrl.sv
module pq_ctrl #(
  parameter int DEPTH = 20,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              wrValid,
  input  logic              rdStrobe,
  output pq_pkg::pqStepT    step,
  output logic [CNT_W-1:0]  wrIdx,
  output logic [CNT_W-1:0]  level,
  output logic              empty,
  output logic              full
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

  logic [CNT_W-1:0] countQ, countD;
  logic rdAcc, wrAcc;

  assign empty = (countQ == '0);
  assign full  = (countQ == DEPTH_C);
  assign level = countQ;

  always_comb begin
    rdAcc = rdStrobe && !empty && !flush;
    wrAcc = wrValid && (!full || rdAcc) && !flush;
    step.shift = rdAcc;
    step.load  = wrAcc;
    // after a shift the tail slot moves down one place
    wrIdx = rdAcc ? (countQ - ONE_C) : countQ;
    if (flush)               countD = '0;
    else if (wrAcc && !rdAcc) countD = countQ + ONE_C;
    else if (rdAcc && !wrAcc) countD = countQ - ONE_C;
    else                     countD = countQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) countQ <= '0;
    else       countQ <= countD;
  end

  a_r2_write_grows: assert property (@(posedge clk) disable iff (!rstN)
    (!flush && wrValid && !rdStrobe && !full) |=> (level == $past(level) + ONE_C));
  a_r3_read_shrinks: assert property (@(posedge clk) disable iff (!rstN)
    (!flush && rdStrobe && !wrValid && !empty) |=> (level == $past(level) - ONE_C));
  a_r4_pair_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!flush && rdStrobe && wrValid && !empty) |=> (level == $past(level)));
  a_r5_full_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (!flush && wrValid && !rdStrobe && full) |=> full);
  a_r6_empty_read_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (!flush && rdStrobe && !wrValid && empty) |=> empty);
  a_r7_flush_clears: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (empty && !full));
  a_r8_never_beyond: assert property (@(posedge clk) disable iff (!rstN)
    (level <= DEPTH_C));
endmodule

// File: rtl/pq_datapath.sv
module pq_datapath #(
  parameter int DEPTH = 20,
  parameter int WIDTH = 32,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  pq_pkg::pqStepT    step,
  input  logic [CNT_W-1:0]  wrIdx,
  input  logic [WIDTH-1:0]  wrData,
  output logic [WIDTH-1:0]  headData
);
  logic [WIDTH-1:0] stageQ [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic [WIDTH-1:0] upper;
    if (i == DEPTH - 1) begin : g_top
      assign upper = stageQ[i];
    end else begin : g_mid
      assign upper = stageQ[i+1];
    end
    always_ff @(posedge clk) begin
      if (step.load && (wrIdx == CNT_W'(i))) stageQ[i] <= wrData;
      else if (step.shift)                   stageQ[i] <= upper;
    end
  end

  assign headData = stageQ[0];

  a_r2_word_lands: assert property (@(posedge clk) disable iff (!rstN)
    step.load |=> (stageQ[$past(wrIdx)] == $past(wrData)));
  a_r3_shift_to_head: assert property (@(posedge clk) disable iff (!rstN)
    (step.shift && !(step.load && wrIdx == '0)) |=> (headData == $past(stageQ[1])));
endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue #(
  parameter int DEPTH = 20,
  parameter int WIDTH = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             wrValid,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdStrobe,
  output logic [WIDTH-1:0] headData,
  output logic             empty,
  output logic             full,
  output logic [CNT_W-1:0] level
);
  pq_pkg::pqStepT step;
  logic [CNT_W-1:0] wrIdx;

  pq_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .flush(flush), .wrValid(wrValid),
    .rdStrobe(rdStrobe), .step(step), .wrIdx(wrIdx), .level(level),
    .empty(empty), .full(full)
  );

  pq_datapath #(.DEPTH(DEPTH), .WIDTH(WIDTH), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .step(step), .wrIdx(wrIdx),
    .wrData(wrData), .headData(headData)
  );
endmodule

// File: tb/prefetch_queue_bench.sv
module prefetch_queue_bench;
  localparam int DEPTH = 20;
  localparam int WIDTH = 32;

  logic clk = 0;
  logic rstN = 0;
  logic flush = 0, wrValid = 0, rdStrobe = 0;
  logic [WIDTH-1:0] wrData = '0;
  logic [WIDTH-1:0] headData;
  logic empty, full;
  logic [4:0] level;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [WIDTH-1:0] model[$];
  logic [WIDTH-1:0] seq = 32'h1000_0000;

  always #5 clk = ~clk;

  prefetch_queue u_prefetch_queue (
    .clk(clk), .rstN(rstN), .flush(flush), .wrValid(wrValid), .wrData(wrData),
    .rdStrobe(rdStrobe), .headData(headData), .empty(empty), .full(full),
    .level(level)
  );

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(string tag);
    check(tag, "level", 32'(level), 32'(model.size()));
    check("R8", "empty", 32'(empty), 32'(model.size() == 0));
    check("R8", "full", 32'(full), 32'(model.size() == DEPTH));
    if (model.size() != 0) check(tag, "head", headData, model[0]);
  endtask

  // one clock: drive at negedge, update model, sample 2 ns after the edge
  task automatic step(bit wv, bit rd, bit fl, string tag);
    bit rdA, wrA;
    @(negedge clk);
    wrValid = wv; rdStrobe = rd; flush = fl;
    seq = seq + 32'h0001_0003;
    wrData = seq;
    if (fl) model.delete();
    else begin
      rdA = rd && model.size() > 0;
      wrA = wv && (model.size() < DEPTH || rdA);
      if (rdA) void'(model.pop_front());
      if (wrA) model.push_back(seq);
    end
    @(posedge clk); #2;
    wrValid = 0; rdStrobe = 0; flush = 0;
    compareAll(tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1", "level", 32'(level), 0);
    check("R1", "empty", 32'(empty), 1);
    check("R1", "full", 32'(full), 0);
    @(negedge clk); rstN = 1;

    // R2: first word visible one clock after write
    step(1, 0, 0, "R2");
    // fill to full, then write while full (R5)
    for (int i = 1; i < DEPTH; i++) step(1, 0, 0, "R2");
    step(1, 0, 0, "R5");
    step(1, 0, 0, "R5");
    // paired read/write at full (R4)
    step(1, 1, 0, "R4");
    // back-to-back drain at full rate (R3)
    for (int i = 0; i < DEPTH; i++) step(0, 1, 0, "R3");
    // read while empty (R6), then paired with write
    step(0, 1, 0, "R6");
    step(1, 1, 0, "R6");
    // flush overriding write and read (R7)
    step(1, 0, 0, "R7");
    step(1, 1, 1, "R7");

    // sweep: every level x every input combination
    for (int lvl = 0; lvl <= DEPTH; lvl++) begin
      for (int c = 0; c < 8; c++) begin
        step(0, 0, 1, "R7");
        for (int k = 0; k < lvl; k++) step(1, 0, 0, "R2");
        step(c[0], c[1], c[2], c[2] ? "R7" : (c[0] && c[1]) ? "R4" :
             (c[0] && lvl == DEPTH) ? "R5" : (c[1] && lvl == 0) ? "R6" :
             c[1] ? "R3" : "R2");
        step(0, 1, 0, "R9");
      end
    end

    // random mixes, biased both ways
    for (int n = 0; n < 4000; n++) begin
      int bias = (n / 500) % 2;
      bit wv = ($urandom_range(0, 9) < (bias ? 8 : 4));
      bit rd = ($urandom_range(0, 9) < (bias ? 4 : 8));
      bit fl = ($urandom_range(0, 199) == 0);
      step(wv, rd, fl, "R9");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule